// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer with Byte Lanes

This block sits between a clocked on-chip request port and an external asynchronous static RAM of 128K words by 16 bits. It accepts single-word read or write requests, each with a 17-bit word address and a two-bit lane mask. It then produces registered, active-low select, write, output and per-lane byte strobes, together with a tri-state data path. That path is split into a data-out vector, a per-lane drive enable and a data-in vector. Every access time the memory needs is given as a picosecond parameter. Each one becomes a whole number of clock cycles, rounded up, with a floor of one cycle.

The request side is a valid/ready port. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold `req_valid` and all request fields stable. `req_ready` drops on the accepting edge. It rises again in the final cycle of the current operation, so a new request can follow with no dead cycle. Read results have no back-pressure. `rd_valid` is a one-cycle pulse and the consumer must take `rd_data` in that cycle.

During writes the sequencer keeps the memory output enable inactive, which allows the shorter write-pulse length. After a read it never turns its drivers on until one cycle has passed with the memory deselected.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Out of reset and whenever no operation is in progress, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11, `mem_dq_oe` is 2'b00, `req_ready` is 1 and `rd_valid` is 0. Whenever `mem_ce_n` is 1, the other strobes are inactive and nothing is driven.
- R2: In every cycle of a read, `mem_ce_n`=0, `mem_we_n`=1 and `mem_oe_n`=0. `mem_be_n[i]` is the inverse of mask bit i, where bit 0 is lane 0 = data bits 7:0 and bit 1 is lane 1 = bits 15:8. `mem_addr` equals the request address. With defaults (5 ns clock, 10 ns access), a read lasts 2 cycles.
- R3: `rd_data` is sampled from `mem_dq_i` on the edge that ends a read. `rd_valid` is high for exactly the following cycle. Lanes outside the mask read as zero.
- R4: `req_ready` is 0 from the accepting edge until the final cycle of the operation, where it is 1. A read is 2 cycles long. A write is 3 cycles long (2 of pulse, 1 of recovery). Back-to-back reads keep `mem_ce_n` low and deliver results every 2 cycles.
- R5: A write holds `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for the write-pulse count (2 cycles with defaults). The write then ends with `mem_we_n` and `mem_ce_n` rising on the same edge.
- R6: Only while `mem_we_n` is 0 does the sequencer drive data. It drives only the lanes in the mask (`mem_dq_oe[i]`=1 and `mem_be_n[i]`=0), with `mem_dq_o` equal to the request data.
- R7: A write changes only the masked lanes of the addressed word. The other lane keeps its previous content.
- R8: A write accepted in the last cycle of a read first spends one cycle fully deselected with no drive. Drivers are never enabled in a cycle where the memory output is on, nor in the cycle right after it.
- R9: Between two writes, `mem_we_n` and `mem_ce_n` return high for at least one cycle, so each write forms its own pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Read result, unmasked lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Memory lane enables, active low |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The bench targets the read-to-write hand-over with no idle cycle in between. A design without the turnaround cycle would drive the bus while the memory is still releasing it, and the bus monitor would flag the overlap. It issues back-to-back writes, where a sequencer that leaves the write strobe low merges two writes into one pulse and stores only the second. Partial-lane writes and reads catch a design that drives or stores the unselected byte, or that returns bus garbage in a masked read lane. Cycle-exact sampling of `req_ready` and `rd_valid` exposes an off-by-one in the access or recovery counts.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_READ  = 3'd1,
    SEQ_TURN  = 3'd2,
    SEQ_WRITE = 3'd3,
    SEQ_WREC  = 3'd4
  } seq_state_e;

  // Default clock and memory timing minimums, picoseconds
  localparam int DEF_CLK_PS     = 5000;
  localparam int DEF_T_RC_PS    = 10000;
  localparam int DEF_T_AA_PS    = 10000;
  localparam int DEF_T_OEA_PS   = 5000;
  localparam int DEF_T_BEA_PS   = 6000;
  localparam int DEF_T_WC_PS    = 10000;
  localparam int DEF_T_WP_PS    = 8000;
  localparam int DEF_T_DS_PS    = 5000;
  localparam int DEF_T_REL_PS   = 5000;

  function automatic int ceil_cycles(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt;

  // Holds the number of cycles left in the current phase, this one included
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == {{(CW-1){1'b0}}, 1'b1});

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
#(
  parameter int CW     = 4,
  parameter int RD_N   = 2,
  parameter int TURN_N = 1,
  parameter int WP_N   = 2,
  parameter int WREC_N = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          phase_last,
  output seq_state_e    nxt,
  output logic          ready,
  output logic          accept,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          capture
);

  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    // ready rises in the last cycle of a read or of write recovery
    ready  = (state == SEQ_IDLE) ||
             (phase_last && (state == SEQ_READ || state == SEQ_WREC));
    accept = ready && req_valid;

    nxt = state;
    unique case (state)
      SEQ_IDLE:  nxt = SEQ_IDLE;
      SEQ_READ:  if (phase_last) nxt = SEQ_IDLE;
      SEQ_TURN:  if (phase_last) nxt = SEQ_WRITE;
      SEQ_WRITE: if (phase_last) nxt = SEQ_WREC;
      SEQ_WREC:  if (phase_last) nxt = SEQ_IDLE;
      default:   nxt = SEQ_IDLE;
    endcase

    if (accept) begin
      if (!req_write)              nxt = SEQ_READ;
      else if (state == SEQ_READ)  nxt = SEQ_TURN;   // bus hand-over gap
      else                         nxt = SEQ_WRITE;
    end

    load = accept || (phase_last && (state == SEQ_TURN || state == SEQ_WRITE));

    unique case (nxt)
      SEQ_READ:  load_val = CW'(RD_N);
      SEQ_TURN:  load_val = CW'(TURN_N);
      SEQ_WRITE: load_val = CW'(WP_N);
      SEQ_WREC:  load_val = CW'(WREC_N);
      default:   load_val = '0;
    endcase

    capture = (state == SEQ_READ) && phase_last;
  end

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_next,
  input  logic         strobe_next,
  input  logic         write_next,
  input  logic [W-1:0] wdata_next,
  input  logic         capture,
  input  logic         cap_sel,
  input  logic [W-1:0] din,
  output logic         be_n,
  output logic         drive,
  output logic [W-1:0] dout,
  output logic [W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_n  <= 1'b1;
      drive <= 1'b0;
      dout  <= '0;
      rdata <= '0;
    end else begin
      be_n  <= !(strobe_next && sel_next);
      drive <= write_next && sel_next;
      if (write_next) dout <= wdata_next;
      if (capture)    rdata <= cap_sel ? din : '0;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int CLK_PS   = DEF_CLK_PS,
  parameter int T_RC_PS  = DEF_T_RC_PS,
  parameter int T_AA_PS  = DEF_T_AA_PS,
  parameter int T_OEA_PS = DEF_T_OEA_PS,
  parameter int T_BEA_PS = DEF_T_BEA_PS,
  parameter int T_WC_PS  = DEF_T_WC_PS,
  parameter int T_WP_PS  = DEF_T_WP_PS,
  parameter int T_DS_PS  = DEF_T_DS_PS,
  parameter int T_REL_PS = DEF_T_REL_PS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES-1:0]         req_be,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  output logic                     rd_valid,
  output logic [LANES*LANE_W-1:0]  rd_data,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_ce_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES-1:0]         mem_be_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_o,
  output logic [LANES-1:0]         mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_i
);

  localparam int DATA_W = LANES * LANE_W;
  // Read length covers address, output-enable and lane-enable access plus cycle time
  localparam int RD_N   = imax(imax(ceil_cycles(T_AA_PS, CLK_PS), ceil_cycles(T_RC_PS, CLK_PS)),
                               imax(ceil_cycles(T_OEA_PS, CLK_PS), ceil_cycles(T_BEA_PS, CLK_PS)));
  // Data is driven for the whole pulse, so the pulse also covers data setup
  localparam int WP_N   = imax(ceil_cycles(T_WP_PS, CLK_PS), ceil_cycles(T_DS_PS, CLK_PS));
  localparam int WREC_N = imax(1, ceil_cycles(T_WC_PS, CLK_PS) - WP_N);
  localparam int TURN_N = ceil_cycles(T_REL_PS, CLK_PS);
  localparam int MAX_N  = imax(imax(RD_N, WP_N), imax(WREC_N, TURN_N));
  localparam int CW     = imax(1, $clog2(MAX_N + 1));

  seq_state_e          nxt;
  logic                accept;
  logic                load;
  logic [CW-1:0]       load_val;
  logic                phase_last;
  logic                capture;

  logic [LANES-1:0]    mask_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    mask_next;
  logic [DATA_W-1:0]   wdata_next;
  logic                strobe_next;
  logic                write_next;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (phase_last)
  );

  sram_seq_fsm #(
    .CW     (CW),
    .RD_N   (RD_N),
    .TURN_N (TURN_N),
    .WP_N   (WP_N),
    .WREC_N (WREC_N)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_last (phase_last),
    .nxt        (nxt),
    .ready      (req_ready),
    .accept     (accept),
    .load       (load),
    .load_val   (load_val),
    .capture    (capture)
  );

  assign mask_next   = accept ? req_be    : mask_q;
  assign wdata_next  = accept ? req_wdata : wdata_q;
  assign strobe_next = (nxt == SEQ_READ) || (nxt == SEQ_WRITE);
  assign write_next  = (nxt == SEQ_WRITE);

  // Request latch and registered shared strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      wdata_q  <= '0;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      rd_valid <= 1'b0;
    end else begin
      if (accept) begin
        mask_q   <= req_be;
        wdata_q  <= req_wdata;
        mem_addr <= req_addr;
      end
      mem_ce_n <= !strobe_next;
      mem_we_n <= !write_next;
      mem_oe_n <= !(nxt == SEQ_READ);   // output enable stays off during writes
      rd_valid <= capture;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_io #(.W(LANE_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_next    (mask_next[g]),
      .strobe_next (strobe_next),
      .write_next  (write_next),
      .wdata_next  (wdata_next[g*LANE_W +: LANE_W]),
      .capture     (capture),
      .cap_sel     (mask_q[g]),
      .din         (mem_dq_i[g*LANE_W +: LANE_W]),
      .be_n        (mem_be_n[g]),
      .drive       (mem_dq_oe[g]),
      .dout        (mem_dq_o[g*LANE_W +: LANE_W]),
      .rdata       (rd_data[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk
  import sram_strobe_pkg::*;
#(
  parameter int WP_CYC = imax(ceil_cycles(DEF_T_WP_PS, DEF_CLK_PS), ceil_cycles(DEF_T_DS_PS, DEF_CLK_PS))
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       mem_oe_n,
  input logic [1:0] mem_be_n,
  input logic [1:0] mem_dq_oe
);

  logic [7:0] we_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low <= '0;
    else if (!mem_we_n) we_low <= (we_low == 8'hFF) ? we_low : we_low + 8'd1;
    else                we_low <= '0;
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && mem_be_n == 2'b11 && mem_dq_oe == 2'b00));

  assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !req_ready);

  assert_write_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  assert_we_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low >= 8'(WP_CYC)));

  assert_drive_in_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != 2'b00) |-> (!mem_we_n && (mem_dq_oe & mem_be_n) == 2'b00));

  assert_rd_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

  assert_turn_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> (mem_dq_oe == 2'b00));

  assert_write_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_ce_n);

endmodule

bind sram_strobe_ctrl sram_strobe_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o;
  logic [1:0]  mem_dq_oe;
  logic [15:0] mem_dq_i;

  int n_chk = 0;
  int n_bad = 0;
  int we_falls = 0;
  int clashes = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  sram_strobe_ctrl u_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory model: 64 words, lanes it does not drive read as 8'hEE
  logic [15:0] model [0:63];
  initial for (int i = 0; i < 64; i++) model[i] = 16'h1000 + 16'(i);

  always_comb begin
    for (int l = 0; l < 2; l++)
      mem_dq_i[l*8 +: 8] = (!mem_ce_n && mem_we_n && !mem_oe_n && !mem_be_n[l])
                           ? model[mem_addr[5:0]][l*8 +: 8] : 8'hEE;
  end

  logic        p_we = 1'b1, p_drv = 1'b0;
  logic [1:0]  p_be = 2'b11;
  logic [15:0] p_dq = '0;
  logic [16:0] p_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_we && !mem_we_n) we_falls++;
      if (!p_we && mem_we_n)
        for (int l = 0; l < 2; l++)
          if (!p_be[l]) model[p_addr[5:0]][l*8 +: 8] = p_dq[l*8 +: 8];
      // R8: no drive while memory outputs, nor one cycle after
      if (mem_dq_oe != 2'b00 && (p_drv || (!mem_ce_n && mem_we_n && !mem_oe_n))) clashes++;
    end
    p_we   = mem_we_n;
    p_be   = mem_be_n;
    p_dq   = mem_dq_o;
    p_addr = mem_addr;
    p_drv  = !mem_ce_n && mem_we_n && !mem_oe_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge of the first cycle of the operation
  task automatic issue(input logic wr, input logic [16:0] a, input logic [1:0] m, input logic [15:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = m; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ce_n idle", 32'(mem_ce_n), 1);
    chk("R1 we_n idle", 32'(mem_we_n), 1);
    chk("R1 oe_n idle", 32'(mem_oe_n), 1);
    chk("R1 be_n idle", 32'(mem_be_n), 2'b11);
    chk("R1 dq_oe idle", 32'(mem_dq_oe), 0);
    chk("R1 ready idle", 32'(req_ready), 1);
    chk("R1 rd_valid idle", 32'(rd_valid), 0);
  endtask

  task automatic t_write_word;
    int f0;
    f0 = we_falls;
    @(negedge clk);
    issue(1'b1, 17'h00012, 2'b11, 16'hA5C3);
    chk("R5 ce_n in write", 32'(mem_ce_n), 0);
    chk("R5 we_n low c1", 32'(mem_we_n), 0);
    chk("R5 oe_n high in write", 32'(mem_oe_n), 1);
    chk("R6 dq_oe both", 32'(mem_dq_oe), 2'b11);
    chk("R6 dq_o data", 32'(mem_dq_o), 16'hA5C3);
    chk("R6 addr", 32'(mem_addr), 17'h00012);
    chk("R4 ready low c1", 32'(req_ready), 0);
    @(negedge clk);
    chk("R5 we_n low c2", 32'(mem_we_n), 0);
    chk("R4 ready low c2", 32'(req_ready), 0);
    @(negedge clk);
    chk("R5 we_n ends", 32'(mem_we_n), 1);
    chk("R5 ce_n ends", 32'(mem_ce_n), 1);
    chk("R6 drive off", 32'(mem_dq_oe), 0);
    chk("R4 ready in recovery", 32'(req_ready), 1);
    @(negedge clk);
    chk("R7 word stored", 32'(model[6'h12]), 16'hA5C3);
    chk("R5 one pulse", 32'(we_falls - f0), 1);
  endtask

  task automatic t_read_word;
    @(negedge clk);
    issue(1'b0, 17'h00012, 2'b11, 16'h0);
    chk("R2 ce_n", 32'(mem_ce_n), 0);
    chk("R2 we_n", 32'(mem_we_n), 1);
    chk("R2 oe_n", 32'(mem_oe_n), 0);
    chk("R2 be_n", 32'(mem_be_n), 2'b00);
    chk("R2 addr", 32'(mem_addr), 17'h00012);
    chk("R4 ready low read c1", 32'(req_ready), 0);
    @(negedge clk);
    chk("R4 ready read c2", 32'(req_ready), 1);
    chk("R3 no early valid", 32'(rd_valid), 0);
    chk("R2 strobes held c2", 32'({mem_ce_n, mem_oe_n}), 2'b00);
    @(negedge clk);
    chk("R3 valid", 32'(rd_valid), 1);
    chk("R3 data", 32'(rd_data), 16'hA5C3);
    chk("R1 deselect after read", 32'(mem_ce_n), 1);
    @(negedge clk);
    chk("R3 valid one cycle", 32'(rd_valid), 0);
  endtask

  task automatic t_byte_lanes;
    @(negedge clk);
    issue(1'b1, 17'h00012, 2'b01, 16'h1111);
    chk("R6 low lane drive", 32'(mem_dq_oe), 2'b01);
    chk("R6 low lane be_n", 32'(mem_be_n), 2'b10);
    repeat (3) @(negedge clk);
    chk("R7 low lane only", 32'(model[6'h12]), 16'hA511);
    issue(1'b1, 17'h00012, 2'b10, 16'h2222);
    chk("R6 high lane drive", 32'(mem_dq_oe), 2'b10);
    repeat (3) @(negedge clk);
    chk("R7 high lane only", 32'(model[6'h12]), 16'h2211);
    issue(1'b0, 17'h00012, 2'b10, 16'h0);
    chk("R2 high lane be_n", 32'(mem_be_n), 2'b01);
    repeat (2) @(negedge clk);
    chk("R3 masked lane zero", 32'(rd_data), 16'h2200);
  endtask

  task automatic t_read_to_write;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'd5; req_be = 2'b11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 17'd6; req_wdata = 16'hBEEF;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 gap ce_n", 32'(mem_ce_n), 1);
    chk("R8 gap no drive", 32'(mem_dq_oe), 0);
    chk("R8 gap we_n", 32'(mem_we_n), 1);
    chk("R3 read before gap", 32'(rd_data), 16'h1005);
    @(negedge clk);
    chk("R8 write after gap", 32'(mem_we_n), 0);
    chk("R8 drive after gap", 32'(mem_dq_oe), 2'b11);
    repeat (3) @(negedge clk);
    chk("R7 write after read", 32'(model[6]), 16'hBEEF);
  endtask

  task automatic t_read_read;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'd7; req_be = 2'b11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = 17'd8;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 first result", 32'(rd_data), 16'h1007);
    chk("R4 first valid", 32'(rd_valid), 1);
    chk("R4 ce_n stays low", 32'(mem_ce_n), 0);
    @(negedge clk);
    chk("R4 gap valid low", 32'(rd_valid), 0);
    @(negedge clk);
    chk("R4 second valid", 32'(rd_valid), 1);
    chk("R4 second result", 32'(rd_data), 16'h1008);
  endtask

  task automatic t_write_write;
    int f0;
    f0 = we_falls;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'd9; req_be = 2'b11; req_wdata = 16'h1234;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = 17'd10; req_wdata = 16'h5678;
    while (!req_ready) @(negedge clk);
    chk("R9 recovery we_n", 32'(mem_we_n), 1);
    chk("R9 recovery ce_n", 32'(mem_ce_n), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second pulse", 32'(mem_we_n), 0);
    repeat (3) @(negedge clk);
    chk("R9 two pulses", 32'(we_falls - f0), 2);
    chk("R9 first word", 32'(model[9]), 16'h1234);
    chk("R9 second word", 32'(model[10]), 16'h5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_word();
    t_read_word();
    t_byte_lanes();
    t_read_to_write();
    t_read_read();
    t_write_write();
    chk("R8 no bus overlap", 32'(clashes), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
      wait (done);
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule